// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from a ring of sixteen transmit descriptors in memory onto a byte-stream transmit port. Whenever the host touches a control register it pulses `kick`, and the engine sweeps the ring from its current position. For every descriptor the host has handed over, it fetches the stored length, streams that many buffer bytes out of memory, writes the descriptor back to the host and pulses a transmit-done event. When the sweep ends it can raise an interrupt pulse.

The descriptor area and the per-slot frame buffers lie at fixed offsets from a base address. The base is the sum of an init pointer and a DMA offset. Memory is a byte-wide synchronous port with a read latency of one cycle. Multi-byte descriptor fields are stored most significant byte first. Framing, checksum generation and collision handling belong to the MAC that follows the stream port.

Top module: `tx_ring_engine`

## Requirements
- R1: When `kick` is high, `stopped` is low and the engine is idle, a sweep starts on the next clock edge, and `busy` stays high until the sweep has finished.
- R2: While `stopped` is high, a `kick` that arrives in the idle state starts nothing: `busy` stays low, no memory access is made and no descriptor changes.
- R3: A descriptor is ready only when its flag byte, at descriptor offset 2, equals exactly 0x83. Any other value, including 0x83 with extra bits set, causes the slot to be skipped and left unchanged.
- R4: The byte count of a ready slot is the two's-complement negation of the 16-bit length. The length's high byte is at descriptor offset 4 and its low byte at offset 5. Bytes are read from the slot's buffer in ascending address order and are presented on `tx_data` with `tx_valid`, and `tx_last` marks the final byte.
- R5: A byte count larger than 1544 is limited to 1544. A count of zero sends no bytes, but the descriptor is still released.
- R6: After each ready slot, the engine writes 0x03 to the flag byte, pulses `tx_done` for one cycle and advances the ring index by one modulo 16. Skipped slots do not advance the index.
- R7: A sweep examines 15 consecutive slots, starting at the current ring index and wrapping modulo 16, so the slot just before the starting index is never looked at. Ready slots are sent in sweep order.
- R8: At the end of every sweep, `irq` pulses for one cycle if `irq_en` is high and either a frame was sent during the sweep or `intr_pending` is high. In any other case `irq` stays low.
- R9: A `kick` that arrives while a sweep is in progress causes exactly one further sweep, which starts from the updated ring index as soon as the current sweep ends.
- R10: The base address is `init_ptr + dma_off`. Descriptor i lies at base + 152 + 8·i, and its buffer lies at base + 280 + 1544·i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Register-write event that requests a sweep |
| stopped | input | 1 | Controller is in the stop state |
| irq_en | input | 1 | Interrupt enable |
| intr_pending | input | 1 | Interrupt summary already set by another source |
| init_ptr | input | 32 | Init block pointer |
| dma_off | input | 32 | DMA offset added to the init pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_done | output | 1 | One-cycle pulse per released descriptor |
| irq | output | 1 | One-cycle interrupt pulse at the end of a sweep |
| busy | output | 1 | A sweep is in progress |

## Verification
Some properties are checked by assertions on every cycle:
- a stopped, idle engine ignores a kick;
- the only value ever written back is 0x03;
- a write never coincides with an outgoing byte;
- `tx_last` only appears on a valid byte;
- `tx_done` lasts one cycle;
- an interrupt never fires without its enable;
- no frame exceeds 1544 bytes.

Other behaviours can only be shown by the bench's scenarios, using a memory model and a byte scoreboard:
- the exact-match ready test;
- the big-endian negated length;
- the sweep window that stops one slot short of a full turn;
- the index advancing only on sent slots;
- the re-sweep after a kick that arrives mid-sweep.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    localparam logic [7:0] READY_FLAG = 8'h83;
    localparam logic [7:0] DONE_FLAG  = 8'h03;
    localparam int         FLAG_OFS   = 2;
    localparam int         LEN_OFS    = 4;

    typedef enum logic [1:0] {
        AK_FLAG,
        AK_LEN_HI,
        AK_LEN_LO,
        AK_BUF
    } addr_kind_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FLAG_RQ,
        S_FLAG_CHK,
        S_LENH_RQ,
        S_LENL_RQ,
        S_LEN_CAP,
        S_STREAM,
        S_DRAIN,
        S_RELEASE,
        S_ADV,
        S_FINISH
    } eng_state_t;

    function automatic logic [15:0] neg_len(input logic [7:0] hi, input logic [7:0] lo);
        return 16'(~{hi, lo} + 16'd1);
    endfunction

endpackage

// File: rtl/tx_addr_gen.sv
module tx_addr_gen
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RING_LOG   = 4,
    parameter int CNT_W      = 11,
    parameter int DESC_BYTES = 8,
    parameter int RING_OFS   = 152,
    parameter int BUF_OFS    = 280,
    parameter int BUF_BYTES  = 1544
) (
    input  logic [ADDR_W-1:0]   init_ptr,
    input  logic [ADDR_W-1:0]   dma_off,
    input  logic [RING_LOG-1:0] slot,
    input  addr_kind_t          kind,
    input  logic [CNT_W-1:0]    bcnt,
    output logic [ADDR_W-1:0]   addr
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] desc_a;
    logic [ADDR_W-1:0] buf_a;

    always_comb begin
        base   = init_ptr + dma_off;
        desc_a = base + ADDR_W'(RING_OFS) + ADDR_W'(slot) * ADDR_W'(DESC_BYTES);
        buf_a  = base + ADDR_W'(BUF_OFS) + ADDR_W'(slot) * ADDR_W'(BUF_BYTES) + ADDR_W'(bcnt);
        case (kind)
            AK_FLAG:   addr = desc_a + ADDR_W'(FLAG_OFS);
            AK_LEN_HI: addr = desc_a + ADDR_W'(LEN_OFS);
            AK_LEN_LO: addr = desc_a + ADDR_W'(LEN_OFS + 1);
            default:   addr = buf_a;
        endcase
    end
endmodule

// File: rtl/tx_stream_out.sv
module tx_stream_out #(
    parameter int CNT_W     = 11,
    parameter int BUF_BYTES = 1544
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  logic       issue_last,
    input  logic [7:0] mem_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last
);
    logic pend_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            pend_q <= issue;
            last_q <= issue_last;
        end
    end

    assign tx_valid = pend_q;
    assign tx_data  = pend_q ? mem_rdata : 8'h00;
    assign tx_last  = last_q;

    // bytes emitted so far in the current frame (checker state)
    logic [CNT_W:0] sent_bytes;
    always_ff @(posedge clk) begin
        if (rst) sent_bytes <= '0;
        else if (tx_valid) sent_bytes <= tx_last ? '0 : sent_bytes + 1'b1;
    end

    // R5: a frame never runs past the buffer size
    a_r5_frame_cap: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (sent_bytes < (CNT_W + 1)'(BUF_BYTES)));

    // R4: the end marker rides only on a valid byte
    a_r4_last_valid: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);
endmodule

// File: rtl/tx_ring_fsm.sv
module tx_ring_fsm
    import tx_ring_pkg::*;
#(
    parameter int RING_LOG  = 4,
    parameter int CNT_W     = 11,
    parameter int BUF_BYTES = 1544
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                kick,
    input  logic                stopped,
    input  logic                irq_en,
    input  logic                intr_pending,
    input  logic [7:0]          mem_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [7:0]          mem_wdata,
    output addr_kind_t          kind,
    output logic [RING_LOG-1:0] slot,
    output logic [CNT_W-1:0]    bcnt,
    output logic                issue,
    output logic                issue_last,
    output logic                tx_done,
    output logic                irq,
    output logic                busy
);
    localparam int                  RING     = 1 << RING_LOG;
    localparam logic [RING_LOG-1:0] SCAN_LEN = RING_LOG'(RING - 1);

    eng_state_t          st;
    logic [RING_LOG-1:0] idx;
    logic [RING_LOG-1:0] scan;
    logic [RING_LOG-1:0] left;
    logic [7:0]          len_hi;
    logic [CNT_W-1:0]    count;
    logic                sent_any;
    logic                rescan;
    logic [15:0]         len_neg;
    logic [CNT_W-1:0]    cnt_next;
    logic                at_end;

    always_comb begin
        len_neg  = neg_len(len_hi, mem_rdata);
        cnt_next = (32'(len_neg) > BUF_BYTES) ? CNT_W'(BUF_BYTES) : CNT_W'(len_neg);
        at_end   = (bcnt == count - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            idx      <= '0;
            scan     <= '0;
            left     <= '0;
            len_hi   <= '0;
            count    <= '0;
            bcnt     <= '0;
            sent_any <= 1'b0;
            rescan   <= 1'b0;
        end else begin
            if (kick && st != S_IDLE) rescan <= 1'b1;
            case (st)
                S_IDLE: begin
                    if (kick && !stopped) begin
                        scan     <= idx;
                        left     <= SCAN_LEN;
                        sent_any <= 1'b0;
                        st       <= S_FLAG_RQ;
                    end
                end
                S_FLAG_RQ:  st <= S_FLAG_CHK;
                S_FLAG_CHK: st <= (mem_rdata == READY_FLAG) ? S_LENH_RQ : S_ADV;
                S_LENH_RQ:  st <= S_LENL_RQ;
                S_LENL_RQ: begin
                    len_hi <= mem_rdata;
                    st     <= S_LEN_CAP;
                end
                S_LEN_CAP: begin
                    count <= cnt_next;
                    bcnt  <= '0;
                    st    <= (cnt_next == '0) ? S_RELEASE : S_STREAM;
                end
                S_STREAM: begin
                    bcnt <= bcnt + 1'b1;
                    if (at_end) st <= S_DRAIN;
                end
                S_DRAIN: st <= S_RELEASE;
                S_RELEASE: begin
                    idx      <= idx + 1'b1;
                    sent_any <= 1'b1;
                    st       <= S_ADV;
                end
                S_ADV: begin
                    scan <= scan + 1'b1;
                    left <= left - 1'b1;
                    st   <= (left == RING_LOG'(1)) ? S_FINISH : S_FLAG_RQ;
                end
                S_FINISH: begin
                    rescan <= 1'b0;
                    if ((rescan || kick) && !stopped) begin
                        scan     <= idx;
                        left     <= SCAN_LEN;
                        sent_any <= 1'b0;
                        st       <= S_FLAG_RQ;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req    = st inside {S_FLAG_RQ, S_LENH_RQ, S_LENL_RQ, S_STREAM, S_RELEASE};
        mem_we     = (st == S_RELEASE);
        mem_wdata  = mem_we ? DONE_FLAG : 8'h00;
        case (st)
            S_LENH_RQ: kind = AK_LEN_HI;
            S_LENL_RQ: kind = AK_LEN_LO;
            S_STREAM:  kind = AK_BUF;
            default:   kind = AK_FLAG;
        endcase
        slot       = scan;
        issue      = (st == S_STREAM);
        issue_last = (st == S_STREAM) && at_end;
        tx_done    = (st == S_RELEASE);
        irq        = (st == S_FINISH) && irq_en && (sent_any || intr_pending);
        busy       = (st != S_IDLE);
    end

    // R2: a stopped, idle engine stays idle on a kick
    a_r2_stop_holds_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && kick && stopped) |=> !busy);

    // R6: the only value written back is the released flag
    a_r6_release_value: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata == 8'h03));

    // R6: the done event is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R8: no interrupt without its enable
    a_r8_irq_enabled: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RING_LOG   = 4,
    parameter int DESC_BYTES = 8,
    parameter int RING_OFS   = 152,
    parameter int BUF_OFS    = 280,
    parameter int BUF_BYTES  = 1544
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic              stopped,
    input  logic              irq_en,
    input  logic              intr_pending,
    input  logic [ADDR_W-1:0] init_ptr,
    input  logic [ADDR_W-1:0] dma_off,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_done,
    output logic              irq,
    output logic              busy
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    addr_kind_t          kind;
    logic [RING_LOG-1:0] slot;
    logic [CNT_W-1:0]    bcnt;
    logic                issue;
    logic                issue_last;

    tx_ring_fsm #(
        .RING_LOG  (RING_LOG),
        .CNT_W     (CNT_W),
        .BUF_BYTES (BUF_BYTES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .kick         (kick),
        .stopped      (stopped),
        .irq_en       (irq_en),
        .intr_pending (intr_pending),
        .mem_rdata    (mem_rdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .kind         (kind),
        .slot         (slot),
        .bcnt         (bcnt),
        .issue        (issue),
        .issue_last   (issue_last),
        .tx_done      (tx_done),
        .irq          (irq),
        .busy         (busy)
    );

    tx_addr_gen #(
        .ADDR_W     (ADDR_W),
        .RING_LOG   (RING_LOG),
        .CNT_W      (CNT_W),
        .DESC_BYTES (DESC_BYTES),
        .RING_OFS   (RING_OFS),
        .BUF_OFS    (BUF_OFS),
        .BUF_BYTES  (BUF_BYTES)
    ) u_addr (
        .init_ptr (init_ptr),
        .dma_off  (dma_off),
        .slot     (slot),
        .kind     (kind),
        .bcnt     (bcnt),
        .addr     (mem_addr)
    );

    tx_stream_out #(
        .CNT_W     (CNT_W),
        .BUF_BYTES (BUF_BYTES)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .issue_last (issue_last),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last)
    );

    // R4: descriptor write-back never overlaps an outgoing byte
    a_r4_quiet_write: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !(mem_req && mem_we));
endmodule

// File: tb/tx_ring_engine_test.sv
module tx_ring_engine_test;
    localparam int unsigned BASE     = 32'h0000_1200;
    localparam int unsigned RING_OFS = 152;
    localparam int unsigned BUF_OFS  = 280;
    localparam int unsigned BUFSZ    = 1544;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kick = 1'b0;
    logic        stopped = 1'b0;
    logic        irq_en = 1'b0;
    logic        intr_pending = 1'b0;
    logic [31:0] init_ptr = 32'h0000_1000;
    logic [31:0] dma_off  = 32'h0000_0200;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        tx_valid, tx_last, tx_done, irq, busy;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    tx_ring_engine uut (
        .clk(clk), .rst(rst), .kick(kick), .stopped(stopped), .irq_en(irq_en),
        .intr_pending(intr_pending), .init_ptr(init_ptr), .dma_off(dma_off),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_done(tx_done), .irq(irq),
        .busy(busy)
    );

    int total = 0;
    int bad   = 0;
    int done_cnt = 0;
    int irq_cnt  = 0;
    int req_cnt  = 0;
    logic [7:0] mem [int unsigned];
    logic [7:0] exp_data [$];
    bit         exp_last [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        end
    end

    // monitor: scoreboard compare and event counters
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) req_cnt++;
            if (tx_done) done_cnt++;
            if (irq) irq_cnt++;
            if (tx_valid) begin
                if (exp_data.size() == 0) begin
                    check(1'b0, "R4 unexpected byte", int'(tx_data), -1);
                end else begin
                    logic [7:0] d;
                    bit l;
                    d = exp_data.pop_front();
                    l = exp_last.pop_front();
                    check(tx_data == d, "R4 byte value", int'(tx_data), int'(d));
                    check(tx_last == l, "R4 last marker", int'(tx_last), int'(l));
                end
            end
        end
    end

    function automatic int unsigned desc_a(input int s);
        return BASE + RING_OFS + 8 * s;
    endfunction

    function automatic int unsigned buf_a(input int s);
        return BASE + BUF_OFS + BUFSZ * s;
    endfunction

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'((s * 37 + k * 11 + 5) & 255);
    endfunction

    // R10: descriptor and buffer placed at the computed addresses, length big-endian
    task automatic put_desc(input int s, input logic [7:0] flag, input int count);
        logic [15:0] neg;
        neg = 16'(-count);
        mem[desc_a(s) + 2] = flag;
        mem[desc_a(s) + 4] = neg[15:8];
        mem[desc_a(s) + 5] = neg[7:0];
        for (int k = 0; k < count && k < int'(BUFSZ); k++) mem[buf_a(s) + k] = pat(s, k);
    endtask

    task automatic expect_frame(input int s, input int n);
        for (int k = 0; k < n; k++) begin
            exp_data.push_back(pat(s, k));
            exp_last.push_back(k == n - 1);
        end
    endtask

    task automatic pulse_kick();
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic run_scan();
        pulse_kick();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic int flag_of(input int s);
        return int'(mem[desc_a(s) + 2]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d0, i0, r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(!busy && !tx_valid && !irq && !tx_done && !mem_req, "R1 reset idle",
              int'({busy, tx_valid, irq, tx_done, mem_req}), 0);

        // R2: stopped ignores kick
        stopped = 1'b1;
        put_desc(0, 8'h83, 4);
        r0 = req_cnt;
        pulse_kick();
        repeat (20) @(negedge clk);
        check(!busy, "R2 stays idle", int'(busy), 0);
        check(req_cnt == r0, "R2 no memory access", req_cnt - r0, 0);
        check(flag_of(0) == 'h83, "R2 flag untouched", flag_of(0), 'h83);

        // R1 R4 R6 R8 R10: single frame
        stopped = 1'b0;
        irq_en  = 1'b1;
        expect_frame(0, 4);
        d0 = done_cnt; i0 = irq_cnt;
        pulse_kick();
        check(busy, "R1 busy after kick", int'(busy), 1);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_data.size() == 0, "R4 all bytes sent", exp_data.size(), 0);
        check(flag_of(0) == 'h03, "R6 flag released", flag_of(0), 'h03);
        check(done_cnt - d0 == 1, "R6 one done pulse", done_cnt - d0, 1);
        check(irq_cnt - i0 == 1, "R8 irq after send", irq_cnt - i0, 1);

        // R3: exact flag compare; idx now 1
        irq_en = 1'b0;
        put_desc(1, 8'h81, 5);
        put_desc(2, 8'hC3, 5);
        put_desc(3, 8'h83, 3);
        expect_frame(3, 3);
        d0 = done_cnt; i0 = irq_cnt;
        run_scan();
        check(exp_data.size() == 0, "R3 ready slot sent", exp_data.size(), 0);
        check(flag_of(1) == 'h81, "R3 near-match 0x81 skipped", flag_of(1), 'h81);
        check(flag_of(2) == 'hC3, "R3 extra bits skipped", flag_of(2), 'hC3);
        check(done_cnt - d0 == 1, "R6 done only for sent", done_cnt - d0, 1);
        check(irq_cnt == i0, "R8 no irq when disabled", irq_cnt - i0, 0);

        // R7: idx 2, sweep covers 2..15,0 so slot 1 is not visited
        put_desc(0, 8'h83, 2);
        put_desc(1, 8'h83, 1);
        expect_frame(0, 2);
        run_scan();
        check(exp_data.size() == 0, "R7 wrapped slot sent", exp_data.size(), 0);
        check(flag_of(1) == 'h83, "R7 slot before start unvisited", flag_of(1), 'h83);

        // R6 R7 R8: idx 3, sweep 3..1 sends 7 then 1, one irq
        irq_en = 1'b1;
        put_desc(7, 8'h83, 6);
        expect_frame(7, 6);
        expect_frame(1, 1);
        d0 = done_cnt; i0 = irq_cnt;
        run_scan();
        check(exp_data.size() == 0, "R7 sweep order", exp_data.size(), 0);
        check(done_cnt - d0 == 2, "R6 two releases", done_cnt - d0, 2);
        check(irq_cnt - i0 == 1, "R8 one irq per sweep", irq_cnt - i0, 1);

        // R5: idx 5, zero length and over-long length
        irq_en = 1'b0;
        put_desc(5, 8'h83, 0);
        put_desc(6, 8'h83, 2000);
        expect_frame(6, 1544);
        d0 = done_cnt;
        run_scan();
        check(exp_data.size() == 0, "R5 clamped frame", exp_data.size(), 0);
        check(flag_of(5) == 'h03, "R5 zero length released", flag_of(5), 'h03);
        check(done_cnt - d0 == 2, "R5 both released", done_cnt - d0, 2);

        // R8: nothing ready but interrupt already pending
        irq_en = 1'b1;
        intr_pending = 1'b1;
        d0 = done_cnt; i0 = irq_cnt;
        run_scan();
        check(irq_cnt - i0 == 1, "R8 pending irq", irq_cnt - i0, 1);
        check(done_cnt == d0, "R8 no release", done_cnt - d0, 0);
        intr_pending = 1'b0;
        irq_en = 1'b0;

        // R9: idx 7, kick mid-sweep re-sweeps and reaches slot 6
        put_desc(7, 8'h83, 100);
        expect_frame(7, 100);
        d0 = done_cnt;
        pulse_kick();
        repeat (30) @(negedge clk);
        put_desc(6, 8'h83, 3);
        expect_frame(6, 3);
        pulse_kick();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_data.size() == 0, "R9 rescan sent late slot", exp_data.size(), 0);
        check(flag_of(6) == 'h03, "R9 late slot released", flag_of(6), 'h03);
        check(done_cnt - d0 == 2, "R9 two releases", done_cnt - d0, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule